// File: doc/BRIEF.md
# Pixel Plot Buffer with Planar Tile Flush

This block sits between a drawing engine and a byte-wide frame buffer RAM. The engine issues plot commands that carry an X/Y coordinate and a color. The block collects pixels that fall in one 8-pixel horizontal run into a primary row buffer, with one dirty flag per pixel. When that run has to leave the buffer, the block hands it to a secondary buffer inside a write-back engine. The engine converts the bitmap pixels into planar tile bytes and writes them to RAM. Meanwhile the primary buffer accepts new plots.

Tiles are 8x8 pixels in planar form. Screen geometry comes from configuration inputs: colour depth, screen height, quadrant (OBJ) layout and a base address. When only part of a run is dirty, the engine reads each plane byte first and replaces only the dirty bits. A read-pixel command empties the primary buffer, waits until RAM writes finish, and then gathers the pixel's bits from every plane. Plot-time colour handling covers dithering and transparency.

Top module: `pxl_plot_buf`

## Requirements
- R1: An accepted plot places its colour in slot (X mod 8) of the run buffer and marks that slot dirty. In RAM, the pixel lands at bit 7-(X mod 8) of each plane byte, so bit 7 is the leftmost pixel.
- R2: When a plot makes all 8 slots dirty, the run is flushed at once. A flush of a fully dirty run writes every plane byte without reading RAM.
- R3: A plot whose Y or X/8 differs from the buffered run flushes the dirty run before the new pixel is stored. If the write-back engine is still busy, cmd_ready is low until the engine is free. A plot that needs no flush is accepted while the engine is busy.
- R4: Flushing a partly dirty run reads each plane byte and replaces only the bits of dirty pixels. All other bits keep their RAM values.
- R5: Depth code 0/1/2 selects 2/4/8 planes, and a tile occupies 8 x planes bytes. Height code 0/1/2 selects 16/20/24 tile rows. Without OBJ layout, the tile index is (X/8) x rows + Y/8. Plane p of pixel row r sits at base + tile x tile_bytes + 16 x (p/2) + 2r + (p mod 2).
- R6: With cfg_obj set, the tile index is Y[7]·512 + X[7]·256 + X[6:3]·16 + Y[6:3]. The two top bits select a 128x128 quadrant.
- R7: With dithering enabled and X XOR Y odd, the plotted colour is the command colour shifted right by 4.
- R8: A colour whose low N bits are zero is transparent and is not stored, with N = 2, 4 or 8 by depth. In 8-plane mode with cfg_freeze_hi set, only the low 4 bits are tested. cfg_keep_clear stores transparent colours too.
- R9: A read-pixel command flushes any dirty run and waits for the write-back to finish. It then returns the stored pixel on rpix_data, with bits above the plane count zero, during a single-cycle rpix_valid pulse. No command is accepted while it is pending.
- R10: Once ram_req is raised, ram_req, ram_we, ram_addr and ram_wdata hold until a cycle with ram_ready high. Read data is taken in that cycle.
- R11: After reset, no RAM request is made, rpix_valid is low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 2 | Plane count code (0:2, 1:4, 2/3:8) |
| cfg_height | input | 2 | Screen height code (0:128, 1:160, 2/3:192) |
| cfg_obj | input | 1 | Quadrant layout enable |
| cfg_base | input | AW | Frame buffer base byte address |
| cfg_dither | input | 1 | Dither enable |
| cfg_keep_clear | input | 1 | Store transparent colours |
| cfg_freeze_hi | input | 1 | Restrict 8-plane transparency test to low nibble |
| cmd_valid | input | 1 | Command present |
| cmd_rpix | input | 1 | Command is read-pixel (else plot) |
| cmd_x | input | 8 | X coordinate |
| cmd_y | input | 8 | Y coordinate |
| cmd_color | input | 8 | Plot colour |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| rpix_valid | output | 1 | Read-pixel result pulse |
| rpix_data | output | 8 | Read-pixel result |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write (else read) |
| ram_addr | output | AW | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_ready | input | 1 | RAM access completes this cycle |
| ram_rdata | input | 8 | RAM read data, valid with ram_ready |

## Verification
The checker watches several properties on every cycle. It checks that RAM requests and their payload stay stable until accepted, and that the run buffer is never left fully dirty. It checks that a refused plot coincides with a busy engine or a pending read-pixel, and that rpix_valid lasts one cycle. Only the bench scenarios can show the deeper behaviour: tile and plane address arithmetic for each depth, height and quadrant layout, bit-exact merging of partial runs, the absence of reads on a full run, and the dither and transparency rules. The bench checks these by decoding its RAM model and reading pixels back.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  typedef logic [7:0] pix_t;

  function automatic logic [3:0] planes_of(input logic [1:0] depth);
    case (depth)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [2:0] tile_shift_of(input logic [1:0] depth);
    case (depth)
      2'd0:    return 3'd4;
      2'd1:    return 3'd5;
      default: return 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/pxl_prep.sv
module pxl_prep
  import pxl_pkg::*;
(
  input  pix_t       color,
  input  logic       odd_pos,
  input  logic [1:0] depth,
  input  logic       dither,
  input  logic       keep_clear,
  input  logic       freeze_hi,
  output pix_t       eff,
  output logic       store
);
  logic clear;

  always_comb begin
    eff = (dither && odd_pos) ? {4'h0, color[7:4]} : color;
    case (depth)
      2'd0:    clear = (eff[1:0] == 2'd0);
      2'd1:    clear = (eff[3:0] == 4'd0);
      default: clear = freeze_hi ? (eff[3:0] == 4'd0) : (eff == 8'd0);
    endcase
    store = keep_clear || !clear;
  end
endmodule

// File: rtl/pxl_addr.sv
module pxl_addr
  import pxl_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic [7:0]    x,
  input  logic [7:0]    y,
  input  logic [1:0]    depth,
  input  logic [1:0]    height,
  input  logic          obj,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] row_addr
);
  localparam int TW = 10;
  logic [TW-1:0] rows_per_col;
  logic [TW-1:0] tile;

  always_comb begin
    case (height)
      2'd0:    rows_per_col = TW'(16);
      2'd1:    rows_per_col = TW'(20);
      default: rows_per_col = TW'(24);
    endcase
    if (obj) tile = {y[7], x[7], x[6:3], y[6:3]};
    else     tile = TW'(x[7:3]) * rows_per_col + TW'(y[7:3]);
    row_addr = base + (AW'(tile) << tile_shift_of(depth)) + AW'({y[2:0], 1'b0});
  end
endmodule

// File: rtl/pxl_flush_engine.sv
module pxl_flush_engine
  import pxl_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          job_rd,
  input  logic [AW-1:0] job_addr,
  input  logic [3:0]    job_planes,
  input  pix_t [7:0]    job_pix,
  input  logic [7:0]    job_mask,
  output logic          busy,
  output logic          done,
  output logic          done_rd,
  output pix_t          rd_pixel,
  output logic          ram_req,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic          ram_ready,
  input  logic [7:0]    ram_rdata
);
  typedef enum logic [1:0] {E_IDLE, E_RD, E_WR} est_t;

  est_t          st_q, st_d;
  logic [3:0]    pl_q, pl_d, planes_q, planes_d;
  pix_t [7:0]    pix_q, pix_d;
  logic [7:0]    mb_q, mb_d, old_q, old_d, acc_q, acc_d, plane_bits, job_mb;
  logic [AW-1:0] addr_q, addr_d;
  logic          rd_q, rd_d, done_q, done_d, drd_q, drd_d, last;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      plane_bits[7-i] = pix_q[i][pl_q[2:0]];
      job_mb[7-i]     = job_mask[i];
    end
  end

  assign last      = (pl_q + 4'd1 == planes_q);
  assign busy      = (st_q != E_IDLE);
  assign ram_req   = busy;
  assign ram_we    = (st_q == E_WR);
  assign ram_addr  = addr_q + AW'({pl_q[2:1], 4'b0000}) + AW'(pl_q[0]);
  assign ram_wdata = (old_q & ~mb_q) | (plane_bits & mb_q);
  assign done      = done_q;
  assign done_rd   = drd_q;
  assign rd_pixel  = acc_q;

  always_comb begin
    st_d = st_q; pl_d = pl_q; planes_d = planes_q; pix_d = pix_q; mb_d = mb_q;
    old_d = old_q; acc_d = acc_q; addr_d = addr_q; rd_d = rd_q;
    done_d = 1'b0; drd_d = 1'b0;
    case (st_q)
      E_IDLE: if (start) begin
        pix_d = job_pix; mb_d = job_mb; addr_d = job_addr; rd_d = job_rd;
        planes_d = job_planes; pl_d = 4'd0; acc_d = 8'd0;
        st_d = (job_rd || job_mask != 8'hFF) ? E_RD : E_WR;
      end
      E_RD: if (ram_ready) begin
        old_d = ram_rdata;
        if (rd_q) begin
          acc_d[pl_q[2:0]] = |(ram_rdata & mb_q);
          if (last) begin st_d = E_IDLE; done_d = 1'b1; drd_d = 1'b1; end
          else pl_d = pl_q + 4'd1;
        end else st_d = E_WR;
      end
      E_WR: if (ram_ready) begin
        if (last) begin st_d = E_IDLE; done_d = 1'b1; end
        else begin
          pl_d = pl_q + 4'd1;
          st_d = (&mb_q) ? E_WR : E_RD;
        end
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= E_IDLE; pl_q <= '0; planes_q <= '0; pix_q <= '0; mb_q <= '0;
      old_q <= '0; acc_q <= '0; addr_q <= '0; rd_q <= 1'b0;
      done_q <= 1'b0; drd_q <= 1'b0;
    end else begin
      st_q <= st_d; pl_q <= pl_d; planes_q <= planes_d; pix_q <= pix_d; mb_q <= mb_d;
      old_q <= old_d; acc_q <= acc_d; addr_q <= addr_d; rd_q <= rd_d;
      done_q <= done_d; drd_q <= drd_d;
    end
  end
endmodule

// File: rtl/pxl_plot_buf.sv
module pxl_plot_buf
  import pxl_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_depth,
  input  logic [1:0]    cfg_height,
  input  logic          cfg_obj,
  input  logic [AW-1:0] cfg_base,
  input  logic          cfg_dither,
  input  logic          cfg_keep_clear,
  input  logic          cfg_freeze_hi,
  input  logic          cmd_valid,
  input  logic          cmd_rpix,
  input  logic [7:0]    cmd_x,
  input  logic [7:0]    cmd_y,
  input  logic [7:0]    cmd_color,
  output logic          cmd_ready,
  output logic          rpix_valid,
  output logic [7:0]    rpix_data,
  output logic          ram_req,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic          ram_ready,
  input  logic [7:0]    ram_rdata
);
  pix_t [7:0]    pix_q, pix_d, pix_aft, job_pix;
  logic [7:0]    dirty_q, dirty_d, dirty_aft, job_mask;
  logic [4:0]    row_x_q, row_x_d;
  logic [7:0]    row_y_q, row_y_d, rp_x_q, rp_x_d, rp_y_q, rp_y_d, rx, ry;
  logic          rp_pend_q, rp_pend_d;
  logic [AW-1:0] row_addr, pt_addr, job_addr;
  pix_t          eff, eng_pixel;
  logic          store, mismatch, full_aft, eng_busy, eng_done, eng_done_rd;
  logic          acc_plot, acc_rp, flush_old, flush_full, rp_flush, rp_read, start;

  pxl_prep u_prep (
    .color(cmd_color), .odd_pos(cmd_x[0] ^ cmd_y[0]), .depth(cfg_depth),
    .dither(cfg_dither), .keep_clear(cfg_keep_clear), .freeze_hi(cfg_freeze_hi),
    .eff(eff), .store(store));

  pxl_addr #(.AW(AW)) u_addr_row (
    .x({row_x_q, 3'b000}), .y(row_y_q), .depth(cfg_depth), .height(cfg_height),
    .obj(cfg_obj), .base(cfg_base), .row_addr(row_addr));

  assign rx = rp_pend_q ? rp_x_q : cmd_x;
  assign ry = rp_pend_q ? rp_y_q : cmd_y;

  pxl_addr #(.AW(AW)) u_addr_pt (
    .x(rx), .y(ry), .depth(cfg_depth), .height(cfg_height),
    .obj(cfg_obj), .base(cfg_base), .row_addr(pt_addr));

  always_comb begin
    mismatch  = (|dirty_q) && (cmd_x[7:3] != row_x_q || cmd_y != row_y_q);
    dirty_aft = mismatch ? 8'd0 : dirty_q;
    pix_aft   = pix_q;
    if (store) begin
      dirty_aft[cmd_x[2:0]] = 1'b1;
      pix_aft[cmd_x[2:0]]   = eff;
    end
    full_aft  = &dirty_aft;
    cmd_ready = !rp_pend_q && (cmd_rpix ? !eng_busy : !(eng_busy && (mismatch || full_aft)));
  end

  assign acc_plot   = cmd_valid && !cmd_rpix && cmd_ready;
  assign acc_rp     = cmd_valid && cmd_rpix && cmd_ready;
  assign flush_old  = acc_plot && mismatch;
  assign flush_full = acc_plot && full_aft;
  assign rp_flush   = acc_rp && (|dirty_q);
  assign rp_read    = (acc_rp && !(|dirty_q)) || (rp_pend_q && !eng_busy);
  assign start      = flush_old || flush_full || rp_flush || rp_read;
  assign job_addr   = rp_read ? pt_addr : row_addr;
  assign job_pix    = flush_full ? pix_aft : pix_q;
  assign job_mask   = rp_read ? (8'd1 << rx[2:0]) : (flush_full ? dirty_aft : dirty_q);

  pxl_flush_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .job_rd(rp_read), .job_addr(job_addr),
    .job_planes(planes_of(cfg_depth)), .job_pix(job_pix), .job_mask(job_mask),
    .busy(eng_busy), .done(eng_done), .done_rd(eng_done_rd), .rd_pixel(eng_pixel),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_ready(ram_ready), .ram_rdata(ram_rdata));

  assign rpix_valid = eng_done && eng_done_rd;
  assign rpix_data  = eng_pixel;

  always_comb begin
    pix_d = pix_q; dirty_d = dirty_q; row_x_d = row_x_q; row_y_d = row_y_q;
    rp_pend_d = rp_pend_q; rp_x_d = rp_x_q; rp_y_d = rp_y_q;
    if (acc_plot) begin
      pix_d   = pix_aft;
      dirty_d = full_aft ? 8'd0 : dirty_aft;
      row_x_d = cmd_x[7:3];
      row_y_d = cmd_y;
    end
    if (rp_flush) begin
      dirty_d = 8'd0; rp_pend_d = 1'b1; rp_x_d = cmd_x; rp_y_d = cmd_y;
    end
    if (rp_pend_q && !eng_busy) rp_pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0; dirty_q <= '0; row_x_q <= '0; row_y_q <= '0;
      rp_pend_q <= 1'b0; rp_x_q <= '0; rp_y_q <= '0;
    end else begin
      pix_q <= pix_d; dirty_q <= dirty_d; row_x_q <= row_x_d; row_y_q <= row_y_d;
      rp_pend_q <= rp_pend_d; rp_x_q <= rp_x_d; rp_y_q <= rp_y_d;
    end
  end
endmodule

// File: rtl/pxl_plot_buf_chk.sv
module pxl_plot_buf_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ram_req,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [7:0]    ram_wdata,
  input logic          ram_ready,
  input logic          rpix_valid,
  input logic          cmd_valid,
  input logic          cmd_rpix,
  input logic          cmd_ready,
  input logic [7:0]    dirty,
  input logic          rp_pend,
  input logic          eng_busy
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req && !ram_ready |=> ram_req && $stable(ram_addr) && $stable(ram_we));

  p_wdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req && ram_we && !ram_ready |=> $stable(ram_wdata));

  p_never_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dirty != 8'hFF);

  p_stall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_rpix && !cmd_ready |-> eng_busy || rp_pend);

  p_rpix_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rpix_valid |=> !rpix_valid);

  p_rp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rp_pend |-> !cmd_ready);
endmodule

bind pxl_plot_buf pxl_plot_buf_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
  .ram_wdata(ram_wdata), .ram_ready(ram_ready), .rpix_valid(rpix_valid),
  .cmd_valid(cmd_valid), .cmd_rpix(cmd_rpix), .cmd_ready(cmd_ready),
  .dirty(dirty_q), .rp_pend(rp_pend_q), .eng_busy(eng_busy));

// File: tb/tb_pxl_plot_buf.sv
module tb_pxl_plot_buf;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_depth = 2'd0, cfg_height = 2'd0;
  logic cfg_obj = 1'b0, cfg_dither = 1'b0, cfg_keep_clear = 1'b0, cfg_freeze_hi = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic cmd_valid = 1'b0, cmd_rpix = 1'b0;
  logic [7:0] cmd_x = '0, cmd_y = '0, cmd_color = '0;
  logic cmd_ready, rpix_valid, ram_req, ram_we;
  logic [7:0] rpix_data, ram_wdata;
  logic [AW-1:0] ram_addr;
  logic ram_ready = 1'b0;
  logic [7:0] ram_rdata = '0;
  logic stall = 1'b0;

  int checks = 0, failures = 0, cycles = 0, rd_cnt = 0;
  logic [7:0] mem [int unsigned];
  logic [7:0] expw [32][16];

  always #2 clk = ~clk;

  pxl_plot_buf #(.AW(AW)) dut (.*);

  function automatic logic [7:0] memrd(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge clk) begin
    ram_ready <= stall ? 1'b0 : ($urandom % 4 != 0);
    ram_rdata <= memrd(int'(ram_addr));
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (ram_req && ram_ready && ram_we) mem[int'(ram_addr)] = ram_wdata;
    if (ram_req && ram_ready && !ram_we) rd_cnt <= rd_cnt + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int planes();
    return (cfg_depth == 0) ? 2 : (cfg_depth == 1) ? 4 : 8;
  endfunction

  function automatic int ref_addr(int x, int y, int p);
    int tile, pc, tb;
    pc = (cfg_height == 0) ? 16 : (cfg_height == 1) ? 20 : 24;
    tb = 8 * planes();
    if (cfg_obj) tile = ((y >> 7) << 9) | ((x >> 7) << 8) | (((x >> 3) & 15) << 4) | ((y >> 3) & 15);
    else tile = (x >> 3) * pc + (y >> 3);
    return int'(cfg_base) + tile * tb + 16 * (p / 2) + 2 * (y % 8) + (p % 2);
  endfunction

  function automatic int decode(int x, int y);
    int v = 0;
    for (int p = 0; p < planes(); p++) begin
      logic [7:0] b = memrd(ref_addr(x, y, p));
      v |= int'(b[7 - x % 8]) << p;
    end
    return v;
  endfunction

  function automatic int dmask();
    return (1 << planes()) - 1;
  endfunction

  // reference colour rules (R7, R8)
  function automatic void model_plot(int x, int y, int c);
    int e, t;
    e = (cfg_dither && ((x ^ y) & 1)) ? (c >> 4) : c;
    t = (cfg_depth == 2 && cfg_freeze_hi) ? (e & 15) : (e & dmask());
    if ((t != 0 || cfg_keep_clear) && x < 32 && y < 16) expw[x][y] = 8'(e & dmask());
  endfunction

  task automatic plot(int x, int y, int c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rpix = 1'b0; cmd_x = 8'(x); cmd_y = 8'(y); cmd_color = 8'(c);
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rpix(int x, int y, output int v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rpix = 1'b1; cmd_x = 8'(x); cmd_y = 8'(y);
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0; cmd_rpix = 1'b0;
    while (!rpix_valid) @(negedge clk);
    v = int'(rpix_data);
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (!ram_req) q++; else q = 0;
    end
  endtask

  task automatic clear_all();
    mem.delete();
    for (int i = 0; i < 32; i++) for (int j = 0; j < 16; j++) expw[i][j] = 8'h00;
  endtask

  initial begin
    int v, bad, x, y, c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R11 ready", int'(cmd_ready), 1);
    chk("R11 ram_req", int'(ram_req), 0);
    chk("R11 rpix_valid", int'(rpix_valid), 0);

    // random phases over every depth (R1 R4 R5 R9)
    for (int d = 0; d < 3; d++) begin
      cfg_depth = 2'(d); cfg_height = 2'($urandom % 3); cfg_base = 17'h00100;
      cfg_dither = 1'($urandom % 2);
      clear_all();
      for (int k = 0; k < 60; k++) begin
        x = $urandom % 32; y = $urandom % 16; c = $urandom % 256;
        model_plot(x, y, c);
        plot(x, y, c);
      end
      for (int k = 0; k < 10; k++) begin
        x = $urandom % 32; y = $urandom % 16;
        rpix(x, y, v);
        chk("R9 R1 random read-back", v, int'(expw[x][y]));
      end
      wait_idle();
      bad = 0;
      for (int i = 0; i < 32; i++) for (int j = 0; j < 16; j++)
        if (decode(i, j) != int'(expw[i][j])) bad++;
      chk("R5 R4 frame decode mismatches", bad, 0);
    end
    cfg_dither = 1'b0;

    // R2: full run, no reads
    cfg_depth = 2'd0; cfg_height = 2'd2; cfg_base = '0; clear_all();
    wait_idle(); rd_cnt = 0;
    for (int i = 0; i < 8; i++) plot(8 + i, 3, (i % 3) + 1);
    wait_idle();
    chk("R2 no reads on full run", rd_cnt, 0);
    bad = 0;
    for (int i = 0; i < 8; i++) if (decode(8 + i, 3) != (i % 3) + 1) bad++;
    chk("R2 full run written", bad, 0);

    // R4: partial merge keeps other bits
    clear_all();
    mem[ref_addr(16, 5, 0)] = 8'hA5; mem[ref_addr(16, 5, 1)] = 8'h3C;
    plot(17, 5, 1);
    plot(40, 5, 2);
    wait_idle();
    chk("R4 plane0 merge", int'(memrd(ref_addr(16, 5, 0))), 32'hE5);
    chk("R4 plane1 merge", int'(memrd(ref_addr(16, 5, 1))), 32'h3C);
    rpix(40, 5, v);
    chk("R3 row-change flush then store", v, 2);

    // R8 transparency
    cfg_depth = 2'd2; clear_all();
    plot(100, 50, 8'h77); plot(102, 50, 8'h77);
    rpix(100, 50, v); chk("R8 opaque stored", v, 32'h77);
    cfg_freeze_hi = 1'b1; plot(100, 50, 8'hF0);
    rpix(100, 50, v); chk("R8 freeze low-nibble transparent", v, 32'h77);
    cfg_freeze_hi = 1'b0; plot(100, 50, 8'hF0);
    rpix(100, 50, v); chk("R8 eight-bit opaque", v, 32'hF0);
    cfg_keep_clear = 1'b1; plot(102, 50, 8'h00);
    rpix(102, 50, v); chk("R8 keep_clear stores zero", v, 0);
    cfg_keep_clear = 1'b0;
    cfg_depth = 2'd0; plot(60, 60, 8'h03); plot(60, 60, 8'h04);
    rpix(60, 60, v); chk("R8 2-plane low bits zero ignored", v, 3);

    // R7 dither
    cfg_depth = 2'd1; cfg_dither = 1'b1; clear_all();
    plot(3, 4, 8'h5A); plot(2, 4, 8'h5A);
    rpix(3, 4, v); chk("R7 odd position high nibble", v, 5);
    rpix(2, 4, v); chk("R7 even position low nibble", v, 32'hA);
    cfg_dither = 1'b0;

    // R6 quadrant layout
    cfg_depth = 2'd0; cfg_obj = 1'b1; clear_all();
    plot(200, 130, 3);
    rpix(200, 130, v); chk("R6 read-back", v, 3);
    chk("R6 plane0 byte", int'(memrd(14596)), 32'h80);
    chk("R6 plane1 byte", int'(memrd(14597)), 32'h80);
    cfg_obj = 1'b0;

    // R3 stall while engine busy
    clear_all(); wait_idle();
    stall = 1'b1;
    for (int i = 0; i < 8; i++) plot(i, 0, 2);
    plot(8, 0, 1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rpix = 1'b0; cmd_x = 8'd16; cmd_y = 8'd0; cmd_color = 8'd1;
    repeat (3) @(negedge clk);
    #1;
    chk("R3 stalled while busy", int'(cmd_ready), 0);
    stall = 1'b0;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
    rpix(16, 0, v); chk("R3 stalled plot stored", v, 1);
    rpix(8, 0, v);  chk("R3 earlier plot stored", v, 1);
    rpix(3, 0, v);  chk("R2 first run stored", v, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule